// File: doc/BRIEF.md
# Hot Plug Detect Pulse Classifier

This block watches the hot plug detect level coming back from a display sink and decides what each low excursion means. The raw level first passes through a two-flop synchronizer. A prescaler driven by a programmable clock-ticks-per-microsecond input then measures how long the level has held since its last change. The block sorts every low period into one of three outcomes. A short dip is a glitch and is dropped. A dip of medium width that returns high is an interrupt request from the sink. A low level that goes on past the removal limit means the sink has been unplugged.

The block keeps a sink-present flag and drives an enable for the main data lanes from it. A removal turns the lanes off but leaves the auxiliary-channel sideband switch closed. The switch status closes when a sink is first seen after reset and stays closed from then on. After a removal, a sink counts as present again only when the level has stayed high for an unbroken debounce interval.

Top module: `hpd_pulse_classifier`

## Requirements
- R1: While reset is asserted and right after it, sink_present, dp_lanes_enable, aux_switch_closed, irq_pulse and unplug_event are all 0.
- R2: sink_present and dp_lanes_enable rise only after the synchronized level has been high for DEBOUNCE_US (default 100) microseconds without a break. A low dip during that wait restarts the count.
- R3: While a sink is present, a low period shorter than IRQ_MIN_US (default 500) microseconds causes no irq_pulse and no unplug_event, and sink_present stays 1.
- R4: While a sink is present, a low period of at least IRQ_MIN_US and less than IRQ_MAX_US (default 1000) microseconds that ends with a return high gives exactly one irq_pulse, one cycle wide. sink_present stays 1.
- R5: While a sink is present, a low period of at least IRQ_MAX_US and less than UNPLUG_US (default 2000) microseconds that ends with a return high gives no event, and sink_present stays 1.
- R6: When a low period reaches UNPLUG_US microseconds while a sink is present, unplug_event pulses for one cycle. In that same cycle sink_present and dp_lanes_enable become 0. The pulse fires once per low period, and the later rising edge gives no further event.
- R7: aux_switch_closed goes to 1 with the first presence after reset and stays 1 through removals until the next reset.
- R8: All thresholds are counted in microseconds, each made of ticks_per_us clock cycles (a value of 0 acts as 1). The same cycle count can therefore be classified differently under different ticks_per_us.
- R9: A low pulse that ends while no sink is present gives no irq_pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hpd_raw | input | 1 | Unsynchronized hot plug detect level |
| ticks_per_us | input | 8 | Clock cycles per microsecond |
| sink_present | output | 1 | Sink attached and debounced |
| irq_pulse | output | 1 | One-cycle interrupt request from the sink |
| unplug_event | output | 1 | One-cycle removal indication |
| dp_lanes_enable | output | 1 | Enable for the main data lanes |
| aux_switch_closed | output | 1 | Auxiliary sideband switch closed |

## Verification
The hardest case to reach is the debounce restart. To get there the stimulus must first cause a real removal, then bring the level back high, and then break that high period with a dip that would count as an interrupt if a sink were present. It does this with a long low hold, a short high hold, a 700-cycle dip and two high holds, checking presence and the interrupt count after each step. The boundaries of the classification window are approached from both sides by table entries placed about 20 cycles on either side of each threshold. A separate run with four ticks per microsecond shows that the limits move with the scale.

// File: rtl/hpd_pkg.sv
package hpd_pkg;

  // A zero scale value is treated as one tick per microsecond.
  function automatic int unsigned eff_tpu(int unsigned t);
    return (t == 0) ? 1 : t;
  endfunction

  // True when a completed low duration falls inside the interrupt window.
  function automatic logic in_irq_window(int unsigned low_us, int unsigned lo, int unsigned hi);
    return (low_us >= lo) && (low_us < hi);
  endfunction

endpackage

// File: rtl/hpd_sync.sv
module hpd_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain <= '0;
        else        chain <= d;
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d};
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/hpd_us_timer.sv
module hpd_us_timer
  import hpd_pkg::*;
#(
  parameter int TPU_W = 8,
  parameter int SAT   = 2000,
  localparam int CNT_W = $clog2(SAT + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lvl,
  input  logic [TPU_W-1:0] ticks_per_us,
  output logic             lvl_edge,
  output logic             us_tick,
  output logic [CNT_W-1:0] us_cnt
);
  logic             lvl_q;
  logic [TPU_W-1:0] pre;

  assign lvl_edge = lvl ^ lvl_q;
  assign us_tick  = (32'(pre) == eff_tpu(32'(ticks_per_us)) - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q  <= 1'b0;
      pre    <= '0;
      us_cnt <= '0;
    end else begin
      lvl_q <= lvl;
      if (lvl_edge || us_tick) pre <= '0;
      else                     pre <= pre + 1'b1;
      if (lvl_edge)
        us_cnt <= '0;
      else if (us_tick && (32'(us_cnt) != SAT))
        us_cnt <= us_cnt + 1'b1;
    end
  end

  // R8: the microsecond count saturates and never wraps
  a_r8_cnt_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    32'(us_cnt) <= SAT);
endmodule

// File: rtl/hpd_classifier.sv
module hpd_classifier
  import hpd_pkg::*;
#(
  parameter int IRQ_MIN_US  = 500,
  parameter int IRQ_MAX_US  = 1000,
  parameter int UNPLUG_US   = 2000,
  parameter int DEBOUNCE_US = 100,
  localparam int CNT_W = $clog2(UNPLUG_US + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lvl,
  input  logic             lvl_edge,
  input  logic             us_tick,
  input  logic [CNT_W-1:0] us_cnt,
  output logic             present,
  output logic             irq,
  output logic             unplug,
  output logic             aux_closed
);
  logic rise_seen;
  logic unplug_hit;
  logic attach_hit;
  logic irq_hit;

  assign rise_seen  = lvl_edge & lvl;
  assign unplug_hit = us_tick & ~lvl & ~lvl_edge & present & (32'(us_cnt) == UNPLUG_US - 1);
  assign attach_hit = us_tick & lvl & ~lvl_edge & ~present & (32'(us_cnt) == DEBOUNCE_US - 1);
  assign irq_hit    = rise_seen & present & in_irq_window(32'(us_cnt), IRQ_MIN_US, IRQ_MAX_US);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      present    <= 1'b0;
      irq        <= 1'b0;
      unplug     <= 1'b0;
      aux_closed <= 1'b0;
    end else begin
      irq    <= irq_hit;
      unplug <= unplug_hit;
      if (unplug_hit)      present <= 1'b0;
      else if (attach_hit) present <= 1'b1;
      if (attach_hit)      aux_closed <= 1'b1;
    end
  end

  // R4: interrupt is a single-cycle pulse
  a_r4_irq_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);
  // R6: removal is a single-cycle pulse
  a_r6_unplug_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    unplug |=> !unplug);
  // R6: presence is dropped in the same cycle as the removal pulse
  a_r6_unplug_clears: assert property (@(posedge clk) disable iff (!rst_n)
    unplug |-> !present);
  // R7: switch status never reopens once closed
  a_r7_aux_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    aux_closed |=> aux_closed);
  // R9: an interrupt is only reported while a sink is present
  a_r9_irq_needs_present: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> present);
endmodule

// File: rtl/hpd_pulse_classifier.sv
module hpd_pulse_classifier #(
  parameter int IRQ_MIN_US  = 500,
  parameter int IRQ_MAX_US  = 1000,
  parameter int UNPLUG_US   = 2000,
  parameter int DEBOUNCE_US = 100,
  parameter int SYNC_STAGES = 2,
  parameter int TPU_W       = 8,
  localparam int CNT_W = $clog2(UNPLUG_US + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hpd_raw,
  input  logic [TPU_W-1:0] ticks_per_us,
  output logic             sink_present,
  output logic             irq_pulse,
  output logic             unplug_event,
  output logic             dp_lanes_enable,
  output logic             aux_switch_closed
);
  logic             hpd_lvl;
  logic             lvl_edge;
  logic             us_tick;
  logic [CNT_W-1:0] us_cnt;

  hpd_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(hpd_raw), .q(hpd_lvl)
  );

  hpd_us_timer #(.TPU_W(TPU_W), .SAT(UNPLUG_US)) u_timer (
    .clk(clk), .rst_n(rst_n), .lvl(hpd_lvl), .ticks_per_us(ticks_per_us),
    .lvl_edge(lvl_edge), .us_tick(us_tick), .us_cnt(us_cnt)
  );

  hpd_classifier #(
    .IRQ_MIN_US(IRQ_MIN_US), .IRQ_MAX_US(IRQ_MAX_US),
    .UNPLUG_US(UNPLUG_US), .DEBOUNCE_US(DEBOUNCE_US)
  ) u_class (
    .clk(clk), .rst_n(rst_n), .lvl(hpd_lvl), .lvl_edge(lvl_edge),
    .us_tick(us_tick), .us_cnt(us_cnt),
    .present(sink_present), .irq(irq_pulse), .unplug(unplug_event),
    .aux_closed(aux_switch_closed)
  );

  assign dp_lanes_enable = sink_present;
endmodule

// File: tb/tb_hpd_pulse_classifier.sv
module tb_hpd_pulse_classifier;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [15:0] low_cycles;
    logic        want_irq;
    logic        want_unplug;
  } vec_t;

  // ticks_per_us = 1: low cycles equal microseconds
  localparam vec_t VECS [11] = '{
    '{16'd100,  1'b0, 1'b0},   // R3 glitch
    '{16'd300,  1'b0, 1'b0},   // R3
    '{16'd480,  1'b0, 1'b0},   // R3 just under window
    '{16'd520,  1'b1, 1'b0},   // R4 just inside
    '{16'd700,  1'b1, 1'b0},   // R4
    '{16'd980,  1'b1, 1'b0},   // R4 upper edge
    '{16'd1020, 1'b0, 1'b0},   // R5
    '{16'd1500, 1'b0, 1'b0},   // R5
    '{16'd1980, 1'b0, 1'b0},   // R5 just under removal
    '{16'd2030, 1'b0, 1'b1},   // R6
    '{16'd2600, 1'b0, 1'b1}    // R6
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       hpd_raw = 1'b0;
  logic [7:0] ticks_per_us = 8'd1;
  logic sink_present, irq_pulse, unplug_event, dp_lanes_enable, aux_switch_closed;

  int checks = 0;
  int fails = 0;
  int irq_seen = 0;
  int unplug_seen = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hpd_pulse_classifier dut (
    .clk(clk), .rst_n(rst_n), .hpd_raw(hpd_raw), .ticks_per_us(ticks_per_us),
    .sink_present(sink_present), .irq_pulse(irq_pulse), .unplug_event(unplug_event),
    .dp_lanes_enable(dp_lanes_enable), .aux_switch_closed(aux_switch_closed)
  );

  always @(posedge clk) begin
    if (irq_pulse)    irq_seen++;
    if (unplug_event) unplug_seen++;
  end

  task automatic check(input bit ok, input string req, input int actual, input int expected);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, actual, expected);
    end
  endtask

  task automatic hold(input logic level, input int n);
    hpd_raw = level;
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      summary();
    end
  end

  initial begin
    int i0, u0;
    hold(1'b0, 5);
    check(sink_present == 0 && dp_lanes_enable == 0, "R1 presence in reset", sink_present, 0);
    check(aux_switch_closed == 0, "R1 aux in reset", aux_switch_closed, 0);
    rst_n = 1'b1;
    hold(1'b0, 3);
    check(irq_pulse == 0 && unplug_event == 0 && sink_present == 0, "R1 after reset", irq_pulse + unplug_event, 0);

    // R2: initial attach after debounce
    hold(1'b1, 50);
    check(sink_present == 0, "R2 not yet debounced", sink_present, 0);
    hold(1'b1, 100);
    check(sink_present == 1 && dp_lanes_enable == 1, "R2 attached", sink_present, 1);
    check(aux_switch_closed == 1, "R7 closes on attach", aux_switch_closed, 1);

    // table walk
    foreach (VECS[k]) begin
      i0 = irq_seen; u0 = unplug_seen;
      hold(1'b0, int'(VECS[k].low_cycles));
      hold(1'b1, 200);
      check(irq_seen - i0 == int'(VECS[k].want_irq), "R3/R4/R5 irq count", irq_seen - i0, int'(VECS[k].want_irq));
      check(unplug_seen - u0 == int'(VECS[k].want_unplug), "R5/R6 unplug count", unplug_seen - u0, int'(VECS[k].want_unplug));
      check(sink_present == 1, "R3 R4 R2 presence after pulse", sink_present, 1);
    end

    // R6: removal fires at the crossing, once
    u0 = unplug_seen; i0 = irq_seen;
    hold(1'b0, 1990);
    check(unplug_seen == u0 && sink_present == 1, "R6 before crossing", unplug_seen - u0, 0);
    hold(1'b0, 30);
    check(unplug_seen - u0 == 1, "R6 at crossing", unplug_seen - u0, 1);
    check(sink_present == 0 && dp_lanes_enable == 0, "R6 lanes off", dp_lanes_enable, 0);
    check(aux_switch_closed == 1, "R7 stays closed on removal", aux_switch_closed, 1);
    hold(1'b0, 3000);
    check(unplug_seen - u0 == 1, "R6 fires once", unplug_seen - u0, 1);
    hold(1'b1, 200);
    check(unplug_seen - u0 == 1 && irq_seen == i0, "R6 nothing at rise", unplug_seen - u0, 1);
    check(sink_present == 1, "R2 re-attach", sink_present, 1);

    // R2 restart and R9 no irq while absent
    hold(1'b0, 2100);
    i0 = irq_seen;
    hold(1'b1, 60);
    hold(1'b0, 700);
    hold(1'b1, 60);
    check(sink_present == 0, "R2 debounce restarted", sink_present, 0);
    check(irq_seen == i0, "R9 no irq while absent", irq_seen - i0, 0);
    hold(1'b1, 60);
    check(sink_present == 1, "R2 attach after full high", sink_present, 1);

    // R8: four ticks per microsecond
    ticks_per_us = 8'd4;
    hold(1'b1, 20);
    i0 = irq_seen; u0 = unplug_seen;
    hold(1'b0, 2400);
    hold(1'b1, 500);
    check(irq_seen - i0 == 1, "R8 scaled irq", irq_seen - i0, 1);
    check(unplug_seen == u0, "R8 scaled no unplug", unplug_seen - u0, 0);
    hold(1'b0, 7800);
    check(unplug_seen == u0 && sink_present == 1, "R8 scaled before removal", unplug_seen - u0, 0);
    hold(1'b0, 400);
    check(unplug_seen - u0 == 1 && sink_present == 0, "R8 scaled removal", unplug_seen - u0, 1);
    hold(1'b1, 200);
    check(sink_present == 0, "R8 scaled debounce pending", sink_present, 0);
    hold(1'b1, 300);
    check(sink_present == 1, "R8 scaled attach", sink_present, 1);

    // R7: only reset reopens the switch
    rst_n = 1'b0;
    hold(1'b1, 3);
    check(aux_switch_closed == 0 && sink_present == 0, "R7 R1 cleared by reset", aux_switch_closed, 0);

    done = 1'b1;
    summary();
  end
endmodule